// File: doc/BRIEF.md
# Single-Cycle Four-Register Teaching Processor

This block is a very small processor core in which each instruction takes exactly one clock period, from one rising edge to the next. An internal program store of sixteen 8-bit words is written through a load port while the core is held in reset. After reset is released, the core fetches the word addressed by its program counter. It decodes the word, reads up to two of its four 4-bit registers, and passes them through a small ALU. At the next rising edge it commits the result, the condition flag and the new program counter together.

Constants are built in two steps: one instruction writes the low two bits of a register, and another writes the high two bits. An equality compare sets a one-bit flag. A following branch jumps to an absolute address when that flag is set. A halt instruction freezes the core until the next reset. A debug read port lets the surroundings inspect any register at any time.

The control is a two-state machine. ST_RUN executes one instruction per cycle. ST_HALT holds all state. The transitions are: reset → ST_RUN; ST_RUN → ST_RUN on any instruction except halt; ST_RUN → ST_HALT on halt; ST_HALT → ST_HALT until reset.

Top module: `tiny_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, all four registers, the condition flag and the halted state are cleared, so `pc` reads 0, `halted` reads 0 and every register reads 0 through the debug port.
- R2: Instruction word layout: bits [7:4] are the opcode (0 or, 1 and, 2 add, 3 sub, 4 load-low, 5 load-high, 6 compare-equal, 7 branch-if-flag, 8 jump, 15 halt); bits [3:2] are the destination register rd; bits [1:0] are the source register rs or a 2-bit immediate; bits [3:0] are the target of a branch or jump. Every non-branch, non-halt instruction advances `pc` by one, and this includes the unassigned opcodes 9 to 14, which change nothing else.
- R3: The opcodes or, and, add and sub write rd op rs back into rd. Arithmetic wraps modulo 16, and rs is left unchanged.
- R4: When rd equals rs in a register-register instruction, both operands are the value held before the edge (for example, add r2,r2 doubles r2 modulo 16).
- R5: Load-low sets rd to the 2-bit immediate, zero-extended, and clears the upper two bits.
- R6: Load-high replaces bits [3:2] of rd with the immediate and keeps bits [1:0].
- R7: Compare-equal sets the flag to 1 when rd equals rs and to 0 otherwise, and leaves the registers unchanged. No other instruction alters the flag.
- R8: Branch-if-flag loads `pc` with the absolute target when the flag is 1, and otherwise advances by one. It sees a flag written by the instruction immediately before it.
- R9: Jump loads `pc` with the absolute target unconditionally.
- R10: Halt raises `halted` at the edge that executes it, keeps `pc` at the halt address, and leaves all registers, the flag and `pc` unchanged until reset.
- R11: `dbg_data` shows the register selected by `dbg_sel` combinationally, without disturbing execution.
- R12: A rising edge with `prog_we` high writes `prog_data` to program word `prog_addr`. Reset does not clear the program store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Write strobe for the program store |
| prog_addr | input | 4 | Program word address to write |
| prog_data | input | 8 | Instruction word to write |
| dbg_sel | input | 2 | Register chosen for the debug port |
| pc | output | 4 | Current program counter |
| halted | output | 1 | High once a halt has executed |
| dbg_data | output | 4 | Contents of the register chosen by dbg_sel |

## Verification
Two pairs of functions can coincide in one cycle. In the first, a register is both an operand and the destination of the same instruction. The bench provokes this with add r2,r2 and sub r2,r2 for all sixteen values, and expects twice the old value and zero respectively. In the second, the flag is written by a compare at one edge and consumed by a branch at the very next edge. The bench sweeps compare-then-branch over all 256 operand pairs and judges the outcome by the address at which the core comes to rest.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    parameter int unsigned DATA_W    = 4;
    parameter int unsigned REG_CNT   = 4;
    parameter int unsigned SEL_W     = $clog2(REG_CNT);
    parameter int unsigned PC_W      = 4;
    parameter int unsigned OPC_W     = 4;
    parameter int unsigned IMM_W     = 2;
    parameter int unsigned INSTR_W   = OPC_W + 2 * SEL_W;
    parameter int unsigned ROM_DEPTH = 1 << PC_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_OR    = 4'h0,
        OPC_AND   = 4'h1,
        OPC_ADD   = 4'h2,
        OPC_SUB   = 4'h3,
        OPC_LDLO  = 4'h4,
        OPC_LDHI  = 4'h5,
        OPC_CMPEQ = 4'h6,
        OPC_BRF   = 4'h7,
        OPC_JMP   = 4'h8,
        OPC_STOP  = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_OR, ALU_AND, ALU_ADD, ALU_SUB, ALU_PASS
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_REG, SRC_IMM_LO, SRC_IMM_HI, SRC_ZERO
    } src_sel_e;

    typedef enum logic {
        ST_RUN, ST_HALT
    } run_state_e;

    typedef struct packed {
        alu_op_e           alu_op;
        src_sel_e          src;
        logic              reg_we;
        logic              flag_we;
        logic              jmp;
        logic              brf;
        logic              stop;
        logic [SEL_W-1:0]  rd;
        logic [SEL_W-1:0]  rs;
        logic [IMM_W-1:0]  imm;
        logic [PC_W-1:0]   target;
    } ctrl_t;
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl
);
    localparam int unsigned OPC_LSB = INSTR_W - OPC_W;

    logic [OPC_W-1:0] opc;
    assign opc = instr[INSTR_W-1:OPC_LSB];

    always_comb begin
        ctrl         = '0;
        ctrl.alu_op  = ALU_OR;
        ctrl.src     = SRC_REG;
        ctrl.rd      = instr[2*SEL_W-1:SEL_W];
        ctrl.rs      = instr[SEL_W-1:0];
        ctrl.imm     = instr[IMM_W-1:0];
        ctrl.target  = instr[PC_W-1:0];
        unique case (opc)
            OPC_OR:    begin ctrl.alu_op = ALU_OR;   ctrl.reg_we = 1'b1; end
            OPC_AND:   begin ctrl.alu_op = ALU_AND;  ctrl.reg_we = 1'b1; end
            OPC_ADD:   begin ctrl.alu_op = ALU_ADD;  ctrl.reg_we = 1'b1; end
            OPC_SUB:   begin ctrl.alu_op = ALU_SUB;  ctrl.reg_we = 1'b1; end
            OPC_LDLO:  begin ctrl.alu_op = ALU_PASS; ctrl.src = SRC_IMM_LO; ctrl.reg_we = 1'b1; end
            OPC_LDHI:  begin ctrl.alu_op = ALU_PASS; ctrl.src = SRC_IMM_HI; ctrl.reg_we = 1'b1; end
            OPC_CMPEQ: ctrl.flag_we = 1'b1;
            OPC_BRF:   ctrl.brf     = 1'b1;
            OPC_JMP:   ctrl.jmp     = 1'b1;
            OPC_STOP:  ctrl.stop    = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
(
    input  alu_op_e           op,
    input  src_sel_e          src,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b_reg,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] y,
    output logic              eq
);
    localparam int unsigned KEEP_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] b;

    // Four-way operand selector in front of the second ALU input
    always_comb begin
        unique case (src)
            SRC_REG:    b = b_reg;
            SRC_IMM_LO: b = {{KEEP_W{1'b0}}, imm};
            SRC_IMM_HI: b = {imm, a[KEEP_W-1:0]};
            default:    b = '0;
        endcase
    end

    always_comb begin
        unique case (op)
            ALU_OR:   y = a | b;
            ALU_AND:  y = a & b;
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            default:  y = b;
        endcase
    end

    assign eq = (a == b_reg);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rsel_a,
    input  logic [SEL_W-1:0]  rsel_b,
    input  logic [SEL_W-1:0]  rsel_dbg,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    output logic [DATA_W-1:0] rdata_dbg
);
    logic [DATA_W-1:0] word [REG_CNT];

    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && (wsel == SEL_W'(g))) begin
                q <= wdata;
            end
        end
        assign word[g] = q;
    end

    assign rdata_a   = word[rsel_a];
    assign rdata_b   = word[rsel_b];
    assign rdata_dbg = word[rsel_dbg];
endmodule

// File: rtl/tiny_cpu.sv
module tiny_cpu
    import cpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    input  logic [SEL_W-1:0]   dbg_sel,
    output logic [PC_W-1:0]    pc,
    output logic               halted,
    output logic [DATA_W-1:0]  dbg_data
);
    logic [INSTR_W-1:0] rom [ROM_DEPTH];
    logic [INSTR_W-1:0] instr_w;
    ctrl_t              ctrl;
    run_state_e         state_q, state_nx;
    logic [PC_W-1:0]    pc_q, pc_nx;
    logic               cond_q;
    logic               exec;
    logic [DATA_W-1:0]  opa, opb, alu_y;
    logic               alu_eq;

    // Program store: written only through the load port, never reset
    always_ff @(posedge clk) begin
        if (prog_we) begin
            rom[prog_addr] <= prog_data;
        end
    end
    assign instr_w = rom[pc_q];

    cpu_decode u_decode (
        .instr (instr_w),
        .ctrl  (ctrl)
    );

    assign exec = (state_q == ST_RUN);

    cpu_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (exec && ctrl.reg_we),
        .wsel      (ctrl.rd),
        .wdata     (alu_y),
        .rsel_a    (ctrl.rd),
        .rsel_b    (ctrl.rs),
        .rsel_dbg  (dbg_sel),
        .rdata_a   (opa),
        .rdata_b   (opb),
        .rdata_dbg (dbg_data)
    );

    cpu_alu u_alu (
        .op    (ctrl.alu_op),
        .src   (ctrl.src),
        .a     (opa),
        .b_reg (opb),
        .imm   (ctrl.imm),
        .y     (alu_y),
        .eq    (alu_eq)
    );

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN:  if (ctrl.stop) state_nx = ST_HALT;
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_RUN;
        endcase
    end

    // Next program counter
    always_comb begin
        pc_nx = pc_q + PC_W'(1);
        if (!exec || ctrl.stop) begin
            pc_nx = pc_q;
        end else if (ctrl.jmp || (ctrl.brf && cond_q)) begin
            pc_nx = ctrl.target;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_nx;
        end
    end

    // Program counter and condition flag
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            cond_q <= 1'b0;
        end else begin
            pc_q <= pc_nx;
            if (exec && ctrl.flag_we) begin
                cond_q <= alu_eq;
            end
        end
    end

    // Outputs
    always_comb begin
        pc     = pc_q;
        halted = (state_q == ST_HALT);
    end
endmodule

// File: rtl/tiny_cpu_chk.sv
module tiny_cpu_chk
    import cpu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [PC_W-1:0]    pc,
    input logic               halted,
    input logic [INSTR_W-1:0] instr,
    input logic               flag
);
    logic [OPC_W-1:0] opc;
    logic [PC_W-1:0]  tgt;
    assign opc = instr[INSTR_W-1:INSTR_W-OPC_W];
    assign tgt = instr[PC_W-1:0];

    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc))); // R10

    AST_STOP_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (!halted && opc == OPC_STOP) |=> (halted && $stable(pc))); // R10

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!halted && opc != OPC_BRF && opc != OPC_JMP && opc != OPC_STOP)
        |=> (pc == $past(pc) + PC_W'(1))); // R2

    AST_JMP_ABS: assert property (@(posedge clk) disable iff (rst)
        (!halted && opc == OPC_JMP) |=> (pc == $past(tgt))); // R9

    AST_BRF_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!halted && opc == OPC_BRF && flag) |=> (pc == $past(tgt))); // R8

    AST_BRF_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!halted && opc == OPC_BRF && !flag) |=> (pc == $past(pc) + PC_W'(1))); // R8

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (halted || opc != OPC_CMPEQ) |=> $stable(flag)); // R7
endmodule

bind tiny_cpu tiny_cpu_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc),
    .halted (halted),
    .instr  (instr_w),
    .flag   (cond_q)
);

// File: tb/tiny_cpu_tb_top.sv
`timescale 1ns/100ps
module tiny_cpu_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [3:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic [1:0] dbg_sel = '0;
    logic [3:0] pc;
    logic       halted;
    logic [3:0] dbg_data;

    int total = 0;
    int fails = 0;
    logic [7:0] img [16];

    always #2.5 clk = ~clk;

    tiny_cpu dut_i (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .dbg_sel   (dbg_sel),
        .pc        (pc),
        .halted    (halted),
        .dbg_data  (dbg_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic peek(input int i, output int v);
        dbg_sel = i[1:0];
        #0.4;
        v = int'(dbg_data);
    endtask

    task automatic clear_img();
        for (int i = 0; i < 16; i++) img[i] = 8'hF0;
    endtask

    // Holds reset, writes all 16 words, releases reset, runs n instructions
    task automatic load_run(input int n);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            prog_we   = 1'b1;
            prog_addr = i[3:0];
            prog_data = img[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
        rst     = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int v, exp;

        // Sum 1+2+3 with a loop
        clear_img();
        img[0] = 8'h45; img[1] = 8'h54; img[2] = 8'h48; img[3] = 8'h58;
        img[4] = 8'h4F; img[5] = 8'h5C; img[6] = 8'h40; img[7] = 8'h50;
        img[8] = 8'h21; img[9] = 8'h28; img[10] = 8'h63; img[11] = 8'h7D;
        img[12] = 8'h88; img[13] = 8'hF0;
        load_run(22);
        chk("R8 loop exits to halt address", int'(pc), 13);
        chk("R10 not halted before halt executes", int'(halted), 0);
        @(negedge clk);
        chk("R10 halted at halt edge", int'(halted), 1);
        repeat (5) @(negedge clk);
        chk("R10 pc frozen", int'(pc), 13);
        peek(2, v); chk("R3 accumulator sum", v, 6);
        peek(0, v); chk("R3 counter", v, 3);
        peek(1, v); chk("R11 debug r1", v, 1);
        peek(3, v); chk("R11 debug r3", v, 3);

        // Reset state, then rerun from the retained store
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 pc cleared", int'(pc), 0);
        chk("R1 halted cleared", int'(halted), 0);
        for (int r = 0; r < 4; r++) begin
            peek(r, v);
            chk("R1 register cleared", v, 0);
        end
        @(negedge clk);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        peek(2, v); chk("R12 store kept over reset", v, 6);
        chk("R12 halted after rerun", int'(halted), 1);

        // Flag cleared by reset: branch must fall through (flag was 1)
        clear_img();
        img[0] = 8'h73;
        load_run(4);
        chk("R1 flag cleared, branch not taken", int'(pc), 1);

        // Jump is absolute and skips instructions
        clear_img();
        img[0] = 8'h85; img[1] = 8'h41; img[5] = 8'hF0;
        load_run(4);
        chk("R9 jump target", int'(pc), 5);
        peek(0, v); chk("R9 skipped write", v, 0);

        // Unassigned opcodes only advance pc
        clear_img();
        img[0] = 8'h42; img[1] = 8'h9F; img[2] = 8'hE5; img[3] = 8'hF0;
        load_run(6);
        chk("R2 pc after unassigned opcodes", int'(pc), 3);
        peek(0, v); chk("R2 r0 untouched", v, 2);
        peek(1, v); chk("R2 r1 untouched", v, 0);
        peek(3, v); chk("R2 r3 untouched", v, 0);

        // Load-low after load-high clears the upper bits
        clear_img();
        img[0] = 8'h53; img[1] = 8'h41;
        load_run(4);
        peek(0, v); chk("R5 load-low clears high half", v, 1);
        clear_img();
        img[0] = 8'h42; img[1] = 8'h51;
        load_run(4);
        peek(0, v); chk("R6 load-high keeps low half", v, 6);

        // Exhaustive register-register sweep
        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    clear_img();
                    img[0] = 8'(8'h40 | (a & 3));
                    img[1] = 8'(8'h50 | (a >> 2));
                    img[2] = 8'(8'h44 | (b & 3));
                    img[3] = 8'(8'h54 | (b >> 2));
                    img[4] = 8'((op << 4) | 1);
                    load_run(7);
                    case (op)
                        0: exp = a | b;
                        1: exp = a & b;
                        2: exp = (a + b) & 15;
                        default: exp = (a - b) & 15;
                    endcase
                    peek(0, v); chk("R3 alu result", v, exp);
                    peek(1, v); chk("R3 source kept", v, b);
                end
            end
        end

        // Same register as source and destination
        for (int a = 0; a < 16; a++) begin
            clear_img();
            img[0] = 8'(8'h48 | (a & 3));
            img[1] = 8'(8'h58 | (a >> 2));
            img[2] = 8'h2A;
            img[3] = 8'h48 | 8'(a & 3);
            img[4] = 8'h58 | 8'(a >> 2);
            img[5] = 8'h3A;
            load_run(3);
            peek(2, v); chk("R4 add r2,r2 doubles", v, (2 * a) & 15);
            @(negedge clk);
            repeat (3) @(negedge clk);
            peek(2, v); chk("R4 sub r2,r2 zero", v, 0);
        end

        // Compare immediately followed by branch, all operand pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                clear_img();
                img[0] = 8'(8'h40 | (a & 3));
                img[1] = 8'(8'h50 | (a >> 2));
                img[2] = 8'(8'h44 | (b & 3));
                img[3] = 8'(8'h54 | (b >> 2));
                img[4] = 8'h61;
                img[5] = 8'h77;
                load_run(8);
                chk("R7 R8 compare then branch", int'(pc), (a == b) ? 7 : 6);
                peek(0, v); chk("R7 compare leaves rd", v, a);
            end
        end

        summary();
        $finish;
    end
endmodule